// File: doc/BRIEF.md
# Next Instruction Address Unit

This block produces the fetch address for a small 32-bit RISC pipeline. The address is held in a 19-bit counter. On a normal fetch the counter adds one to itself. When the pipeline signals a control transfer, a parallel load port on the counter takes a computed target instead. The target comes from one adder with a multiplexer on each input. For a relative branch the adder sums the incremented address and the sign-extended 16-bit offset. For an absolute jump it passes the low 19 bits of the 26-bit jump field.

The counter loads when either of two conditions holds. The first is the branch control bit together with a true result from an equality comparator on the two 32-bit register operands. The second is the absolute-jump bit on its own. A halt is a jump whose target is its own address, so the counter reloads the same value on every later cycle.

The block has no data stream, so it has no valid/ready interface. All pins are plain control or status, and `stall` is the only flow control. While `stall` is high the address is frozen, whatever the other inputs show. Inputs are sampled on the rising clock edge. `fetch_addr` is the counter register itself, so a decision made on one edge appears on the port right after that edge.

Top module: `nia_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0.
- R2: In a cycle with `stall` high, `fetch_addr` keeps its value, even when a jump or a taken branch is presented.
- R3: With `stall` low and no load, `fetch_addr` becomes `fetch_addr + 1` modulo 2^19, so 0x7FFFF is followed by 0.
- R4: With `stall` low, `br_en` high, `jmp_en` low and `op_a == op_b` on all 32 bits, `fetch_addr` becomes `(fetch_addr + 1 + sext(br_ofs)) mod 2^19`. `br_ofs` is a 16-bit two's-complement value.
- R5: With `br_en` high and the operands differing in any single bit, including bit 31 or bit 0, the branch is not taken and the address steps as in R3.
- R6: With `stall` low and `jmp_en` high, `fetch_addr` becomes `jmp_field[18:0]`. Bits 25:19 of `jmp_field` have no effect.
- R7: When `jmp_en` and a taken branch are both presented, the jump target wins.
- R8: Equal operands with `br_en` low cause no load, and the address steps as in R3.
- R9: A jump whose `jmp_field[18:0]` equals the current `fetch_addr` (a halt) holds `fetch_addr` constant for as long as it is presented.
- R10: A negative branch offset moves the address backward, and a branch target past 0x7FFFF wraps around modulo 2^19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the address counter |
| br_en | input | 1 | Conditional branch control bit |
| jmp_en | input | 1 | Absolute jump control bit |
| op_a | input | 32 | First register operand for the equality test |
| op_b | input | 32 | Second register operand for the equality test |
| br_ofs | input | 16 | Signed branch offset |
| jmp_field | input | 26 | Jump target field; the low 19 bits are used |
| fetch_addr | output | 19 | Current instruction fetch address |

## Verification
All of the block's state is the fetch address register, so any fault inside the block shows up on `fetch_addr` on the first edge after the faulty cycle. A fault in the comparator or in the load logic shows as a step where a load was due, or a load where a step was due. A fault in the multiplexer or in the sign extension shows as a wrong target value, most clearly with negative offsets and when the address wraps. A reference model compares every cycle, so a divergence is reported on the same cycle it first appears. Because the counter has no self-correcting path, one wrong value also shifts every address after it.

// File: rtl/nia_pkg.sv
package nia_pkg;
  // Selects which pair of operands the target adder sums
  typedef enum logic {
    SRC_REL = 1'b0,   // incremented address + sign-extended offset
    SRC_ABS = 1'b1    // jump field low bits + 0
  } tgt_src_e;

  localparam int unsigned ADDR_W_DEF = 19;
  localparam int unsigned OPND_W_DEF = 32;
  localparam int unsigned OFS_W_DEF  = 16;
  localparam int unsigned JFLD_W_DEF = 26;
endpackage

// File: rtl/nia_eq_cmp.sv
module nia_eq_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         equal
);
  logic [W-1:0] diff;

  always_comb begin
    diff  = a ^ b;
    equal = ~|diff;
  end
endmodule

// File: rtl/nia_tgt_adder.sv
module nia_tgt_adder
  import nia_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned OW = 16
) (
  input  tgt_src_e       src,
  input  logic [AW-1:0]  addr_inc,
  input  logic [OW-1:0]  ofs,
  input  logic [AW-1:0]  jaddr,
  output logic [AW-1:0]  target
);
  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] opnd_x;
  logic [AW-1:0] opnd_y;

  generate
    if (OW < AW) begin : g_sext
      assign ofs_ext = {{(AW-OW){ofs[OW-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[AW-1:0];
    end
  endgenerate

  always_comb begin
    opnd_x = (src == SRC_ABS) ? jaddr : addr_inc;
    opnd_y = (src == SRC_ABS) ? '0    : ofs_ext;
    target = opnd_x + opnd_y;
  end
endmodule

// File: rtl/nia_ld_counter.sv
module nia_ld_counter #(
  parameter int unsigned AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] q,
  output logic [AW-1:0] q_inc
);
  assign q_inc = q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (en) begin
      if (load)       q <= din;
      else            q <= q_inc;
    end
  end

  // R2: a disabled counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> q == $past(q));
  // R3: an enabled counter without load steps by one (modulo)
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> q == $past(q) + AW'(1));
  // R4/R6: a load takes the parallel input
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load) |=> q == $past(din));
endmodule

// File: rtl/nia_unit.sv
module nia_unit
  import nia_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned OPND_W = OPND_W_DEF,
  parameter int unsigned OFS_W  = OFS_W_DEF,
  parameter int unsigned JFLD_W = JFLD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              br_en,
  input  logic              jmp_en,
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  input  logic [OFS_W-1:0]  br_ofs,
  input  logic [JFLD_W-1:0] jmp_field,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int unsigned HI_W = JFLD_W - ADDR_W;

  logic              opnd_eq;
  logic              do_load;
  tgt_src_e          src_sel;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] tgt_addr;
  logic [ADDR_W-1:0] jaddr;
  logic [HI_W-1:0]   unused_jhi;

  assign jaddr      = jmp_field[ADDR_W-1:0];
  assign unused_jhi = jmp_field[JFLD_W-1:ADDR_W];

  nia_eq_cmp #(.W(OPND_W)) u_cmp (
    .a     (op_a),
    .b     (op_b),
    .equal (opnd_eq)
  );

  // Jump has priority over a branch through the source select
  assign src_sel = jmp_en ? SRC_ABS : SRC_REL;
  assign do_load = (br_en & opnd_eq) | jmp_en;

  nia_tgt_adder #(.AW(ADDR_W), .OW(OFS_W)) u_add (
    .src      (src_sel),
    .addr_inc (addr_inc),
    .ofs      (br_ofs),
    .jaddr    (jaddr),
    .target   (tgt_addr)
  );

  nia_ld_counter #(.AW(ADDR_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (!stall),
    .load  (do_load),
    .din   (tgt_addr),
    .q     (fetch_addr),
    .q_inc (addr_inc)
  );

  // R6/R7: a jump lands on the jump field low bits, branch or not
  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && jmp_en) |=> fetch_addr == $past(jmp_field[ADDR_W-1:0]));
  // R5: unequal operands never take a branch
  p_noteq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !jmp_en && (op_a != op_b)) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));
  // R9: a self-jump holds the address
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && jmp_en && jmp_field[ADDR_W-1:0] == fetch_addr) |=> $stable(fetch_addr));
  // R2: stall freezes the port
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_addr));
endmodule

// File: tb/tb_nia_unit.sv
`timescale 1ns/1ps
module tb_nia_unit;
  localparam int MASK = 32'h7FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        br_en = 1'b0;
  logic        jmp_en = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] br_ofs = '0;
  logic [25:0] jmp_field = '0;
  logic [18:0] fetch_addr;

  int checks = 0;
  int fails  = 0;
  int exp_addr = 0;

  always #2.5 clk = ~clk;

  nia_unit dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .br_en(br_en), .jmp_en(jmp_en),
    .op_a(op_a), .op_b(op_b), .br_ofs(br_ofs), .jmp_field(jmp_field),
    .fetch_addr(fetch_addr)
  );

  task automatic check(input string req);
    checks++;
    if (int'(fetch_addr) != exp_addr) begin
      fails++;
      $display("FAIL %s: fetch_addr=0x%05h expected=0x%05h at %0t", req, fetch_addr, exp_addr, $time);
    end
  endtask

  // One cycle: inputs set after a falling edge, model updated for the rising edge,
  // output compared at the next falling edge.
  task automatic cyc(input logic s, input logic b, input logic j,
                     input logic [31:0] a, input logic [31:0] bb,
                     input logic [15:0] ofs, input logic [25:0] jf,
                     input string req);
    int nxt;
    stall = s; br_en = b; jmp_en = j; op_a = a; op_b = bb; br_ofs = ofs; jmp_field = jf;
    if (s)                nxt = exp_addr;
    else if (j)           nxt = int'(jf) & MASK;
    else if (b && a == bb) nxt = (exp_addr + 1 + int'($signed(ofs))) & MASK;
    else                  nxt = (exp_addr + 1) & MASK;
    @(posedge clk);
    exp_addr = nxt;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: expired, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    // R1: reset state, with a jump presented
    jmp_en = 1'b1; jmp_field = 26'h155;
    repeat (3) @(negedge clk);
    exp_addr = 0;
    check("R1");
    jmp_en = 1'b0;
    rst_n = 1'b1;
    // R3: plain stepping
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R3");
    // R2: stall with jump and with taken branch
    cyc(1, 0, 1, 0, 0, 0, 26'h777, "R2");
    cyc(1, 1, 0, 9, 9, 16'h0020, 0, "R2");
    // R4: taken branch
    cyc(0, 1, 0, 32'h12345678, 32'h12345678, 16'd10, 0, "R4");
    // R5: operands differ only in bit 31, then only in bit 0
    cyc(0, 1, 0, 32'h80000000, 32'h0, 16'd100, 0, "R5");
    cyc(0, 1, 0, 32'h1, 32'h0, 16'd100, 0, "R5");
    // R8: equal operands without branch bit
    cyc(0, 0, 0, 32'hABCD, 32'hABCD, 16'd50, 0, "R8");
    // R10: negative offset
    cyc(0, 1, 0, 7, 7, 16'hFFFC, 0, "R10");
    // R6: jump with upper field bits set
    cyc(0, 0, 1, 0, 1, 16'd3, 26'h3F81234, "R6");
    // R7: jump and taken branch together
    cyc(0, 1, 1, 5, 5, 16'd200, 26'h40, "R7");
    // R9: halt
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1, 0, 26'h40, "R9");
    // R3: wrap of the counter
    cyc(0, 0, 1, 0, 1, 0, 26'h7FFFF, "R6");
    cyc(0, 0, 0, 0, 1, 0, 0, "R3");
    // R10: branch target wrap forward and backward
    cyc(0, 0, 1, 0, 1, 0, 26'h7FFFE, "R6");
    cyc(0, 1, 0, 3, 3, 16'd5, 0, "R10");
    cyc(0, 1, 0, 3, 3, 16'h8000, 0, "R10");
    // mixed pattern
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0] & lfsr[5], lfsr[1], lfsr[2] & lfsr[7], {28'h0, lfsr[11:8]},
          {28'h0, lfsr[15:12]}, lfsr[31:16], {lfsr[25:0]}, "R4");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule